// File: doc/BRIEF.md
# Interrupt Trigger Notification Issuer

This block turns interrupt source level changes into memory store requests. It holds a level register with one bit for each of up to 20 sources. Bits are numbered from the most significant end, so source n occupies Verilog bit (63 - n). A source event either raises or lowers its level bit. A raising event also queues a notification. Each notification becomes one 64-bit store. The store address comes from a programmable address register whose own bit 0 acts as the valid flag. The store data is a trigger code, ORed with an offset taken from the upper half of an offset register, ORed with the source number.

A control register holds two command bits. One is an interrupt-method bit that freezes all source activity. The other is a reset command bit that pulses an output for one cycle. A further base register carries a valid bit that drives a map enable output. Stores leave on a simple request/acknowledge interface. The request and its data are held until acknowledged. An acknowledge that carries an error sets a sticky flag, and no retry follows.

Software reaches the registers through a 64-bit word interface with a 4-bit word address. Word 0 is the control register, word 1 the capability base, word 2 the notification address, word 3 the offset register and word 4 the read-only level register. Words 5 to 15 are unimplemented. Register writes take effect at the clock edge. Reads are combinational from the current address.

Top module: `trig_notify_top`

## Requirements
- R1: After reset all registers, the level register, `st_req_o`, `map_en_o`, `src_reset_o` and `st_err_flag_o` read 0. A read of any unimplemented word (5 to 15) returns all ones.
- R2: An event with `evt_lvl_i`=1 for source n (n < 20) sets level bit (63 - n), and one with `evt_lvl_i`=0 clears it. Events with index 20 or above change nothing and issue no store.
- R3: While control bit 63 (the method bit) is set, source events are dropped: the level register keeps its value and no store is issued.
- R4: A store is issued only if notification-address bit 0 (valid) is set, both when the event arrives and when the store starts. `st_addr_o` equals that register with bit 0 cleared.
- R5: `st_data_o` equals TRIG_CODE (default 0x8000_0000) ORed with offset-register bits 63:32 placed in bits 31:0, ORed with the source number.
- R6: While `st_req_o` is high and `st_ack_i` is low, the request, address and data stay unchanged on the next cycle.
- R7: Each source holds at most one pending notification. Repeated raising events coalesce into it. When idle, the lowest-numbered pending source is issued next, one cycle after the acknowledge cycle at the earliest.
- R8: A write to the control register stores the written value. If written bit 62 is set, `src_reset_o` is high for exactly the following cycle.
- R9: A capability-base write with bit 0 set, when bit 0 was clear, raises `map_en_o`. A write with bit 0 clear lowers it. The register always stores the written value.
- R10: An acknowledge with `st_err_i` high sets `st_err_flag_o`, which stays set until reset. No retry of that store follows.
- R11: A lowering event clears the level bit and issues no store. The first store after a raising event is requested in the cycle after the event is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i |
| evt_vld_i | input | 1 | Source event valid |
| evt_idx_i | input | 6 | Source number of the event |
| evt_lvl_i | input | 1 | New level of the source (1 raise, 0 lower) |
| st_req_o | output | 1 | Store request |
| st_addr_o | output | 64 | Store address |
| st_data_o | output | 64 | Store data |
| st_ack_i | input | 1 | Store acknowledge |
| st_err_i | input | 1 | Acknowledge carries an error |
| st_err_flag_o | output | 1 | Sticky store error flag |
| map_en_o | output | 1 | Map enable from the capability base valid bit |
| src_reset_o | output | 1 | One-cycle source reset pulse |

## Verification
Several properties are checked on every cycle:
- the level register holds while the method bit is set or an out-of-range event arrives;
- the request is stable until acknowledged;
- the store address never carries the valid bit;
- at most one source is taken at a time;
- the error flag is sticky;
- the reset pulse and map enable changes always trace back to a matching write.

Only the bench scenarios can show the rest:
- coalescing and lowest-first ordering across an acknowledge;
- the exact composition of the store data;
- dropping when the valid bit is clear;
- level bookkeeping over a long random event stream.

// File: rtl/tni_pkg.sv
package tni_pkg;
    localparam int DATA_W     = 64;
    localparam int REG_ADDR_W = 4;
    localparam int SRC_IDX_W  = 6;

    // word addresses of the register file
    localparam logic [REG_ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [REG_ADDR_W-1:0] A_CAP   = 4'd1;
    localparam logic [REG_ADDR_W-1:0] A_NOTIF = 4'd2;
    localparam logic [REG_ADDR_W-1:0] A_OFFS  = 4'd3;
    localparam logic [REG_ADDR_W-1:0] A_LEVEL = 4'd4;

    // bit positions in Verilog numbering (MSB-first bit k == Verilog 63-k)
    localparam int CTRL_METHOD_BIT = 63;
    localparam int CTRL_RST_BIT    = 62;
    localparam int VALID_BIT       = 0;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] cap;
        logic [DATA_W-1:0] notif;
        logic [DATA_W-1:0] offs;
        logic              map_en;
        logic              src_rst;
    } regs_t;

    typedef struct packed {
        logic              req;
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              err;
    } issue_t;
endpackage

// File: rtl/tni_regs.sv
module tni_regs
    import tni_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DATA_W-1:0]     level_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  method_o,
    output logic                  notif_valid_o,
    output logic [DATA_W-1:0]     notif_addr_o,
    output logic [31:0]           offset_hi_o,
    output logic                  map_en_o,
    output logic                  src_reset_o
);
    regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        r_d.src_rst = 1'b0;
        if (wr_i) begin
            unique case (addr_i)
                A_CTRL: begin
                    r_d.ctrl    = wdata_i;
                    r_d.src_rst = wdata_i[CTRL_RST_BIT];
                end
                A_CAP: begin
                    r_d.cap = wdata_i;
                    if (wdata_i[VALID_BIT] && !r_q.cap[VALID_BIT])
                        r_d.map_en = 1'b1;
                    else if (!wdata_i[VALID_BIT])
                        r_d.map_en = 1'b0;
                end
                A_NOTIF: r_d.notif = wdata_i;
                A_OFFS:  r_d.offs  = wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr_i)
            A_CTRL:  rdata_o = r_q.ctrl;
            A_CAP:   rdata_o = r_q.cap;
            A_NOTIF: rdata_o = r_q.notif;
            A_OFFS:  rdata_o = r_q.offs;
            A_LEVEL: rdata_o = level_i;
            default: rdata_o = '1;
        endcase
    end

    assign method_o      = r_q.ctrl[CTRL_METHOD_BIT];
    assign notif_valid_o = r_q.notif[VALID_BIT];
    assign notif_addr_o  = r_q.notif;
    assign offset_hi_o   = r_q.offs[DATA_W-1:32];
    assign map_en_o      = r_q.map_en;
    assign src_reset_o   = r_q.src_rst;

    // R8: a reset pulse always follows a control write with bit 62 set
    p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_reset_o |-> $past(wr_i && addr_i == A_CTRL && wdata_i[CTRL_RST_BIT]));
    // R9: map enable rises only on a capability write with the valid bit set
    p_map_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(map_en_o) |-> $past(wr_i && addr_i == A_CAP && wdata_i[VALID_BIT]));
    // R9: map enable falls only on a capability write with the valid bit clear
    p_map_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(map_en_o) |-> $past(wr_i && addr_i == A_CAP && !wdata_i[VALID_BIT]));
endmodule

// File: rtl/tni_level.sv
module tni_level
    import tni_pkg::*;
#(
    parameter int NUM_SRC = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 evt_vld_i,
    input  logic [SRC_IDX_W-1:0] evt_idx_i,
    input  logic                 evt_lvl_i,
    input  logic                 method_i,
    input  logic                 notif_valid_i,
    input  logic [NUM_SRC-1:0]   take_i,
    output logic [DATA_W-1:0]    level_o,
    output logic [NUM_SRC-1:0]   pend_o
);
    typedef struct packed {
        logic [DATA_W-1:0]  lvl;
        logic [NUM_SRC-1:0] pend;
    } trk_t;

    trk_t s_d, s_q;
    logic [NUM_SRC-1:0] hit;

    // one decoder per source; indices at or above NUM_SRC match nothing
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_dec
        assign hit[n] = evt_vld_i && !method_i && (evt_idx_i == SRC_IDX_W'(n));
    end

    always_comb begin
        s_d      = s_q;
        s_d.pend = s_q.pend & ~take_i;
        for (int n = 0; n < NUM_SRC; n++) begin
            if (hit[n]) begin
                s_d.lvl[DATA_W-1-n] = evt_lvl_i;
                if (evt_lvl_i && notif_valid_i) s_d.pend[n] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.lvl;
    assign pend_o  = s_q.pend;

    // R3: the method bit freezes the level register
    p_method_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        method_i |=> $stable(level_o));
    // R2: out-of-range events leave the level register alone
    p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vld_i && (int'(evt_idx_i) >= NUM_SRC)) |=> $stable(level_o));
endmodule

// File: rtl/tni_issue.sv
module tni_issue
    import tni_pkg::*;
#(
    parameter int                NUM_SRC   = 20,
    parameter logic [DATA_W-1:0] TRIG_CODE = 64'h0000_0000_8000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic               method_i,
    input  logic               notif_valid_i,
    input  logic [DATA_W-1:0]  notif_addr_i,
    input  logic [31:0]        offset_hi_i,
    input  logic               st_ack_i,
    input  logic               st_err_i,
    output logic [NUM_SRC-1:0] take_o,
    output logic               st_req_o,
    output logic [DATA_W-1:0]  st_addr_o,
    output logic [DATA_W-1:0]  st_data_o,
    output logic               err_flag_o
);
    issue_t s_d, s_q;
    logic [SRC_IDX_W-1:0] sel_idx;
    logic                 any_pend;
    logic                 start;

    // lowest pending source wins
    always_comb begin
        sel_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) sel_idx = SRC_IDX_W'(i);
        end
    end

    assign any_pend = |pend_i;
    assign start    = !s_q.req && !method_i && any_pend;
    assign take_o   = start ? (NUM_SRC'(1) << sel_idx) : '0;

    always_comb begin
        s_d = s_q;
        if (s_q.req && st_ack_i) begin
            s_d.req = 1'b0;
            if (st_err_i) s_d.err = 1'b1;
        end
        if (start && notif_valid_i) begin
            s_d.req  = 1'b1;
            s_d.addr = notif_addr_i & ~(DATA_W'(1) << VALID_BIT);
            s_d.data = TRIG_CODE | {32'h0, offset_hi_i} | DATA_W'(sel_idx);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign st_req_o   = s_q.req;
    assign st_addr_o  = s_q.addr;
    assign st_data_o  = s_q.data;
    assign err_flag_o = s_q.err;

    // R6: request and payload hold until acknowledged
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req_o && !st_ack_i) |=> (st_req_o && $stable(st_addr_o) && $stable(st_data_o)));
    // R4: the valid flag never reaches the bus address
    p_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_req_o |-> !st_addr_o[VALID_BIT]);
    // R7: at most one source is taken per cycle
    p_take_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take_o));
    // R10: the error flag is sticky
    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag_o |=> err_flag_o);
endmodule

// File: rtl/trig_notify_top.sv
module trig_notify_top
    import tni_pkg::*;
#(
    parameter int                NUM_SRC   = 20,
    parameter logic [DATA_W-1:0] TRIG_CODE = 64'h0000_0000_8000_0000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr_i,
    input  logic [REG_ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]     reg_wdata_i,
    output logic [DATA_W-1:0]     reg_rdata_o,
    input  logic                  evt_vld_i,
    input  logic [SRC_IDX_W-1:0]  evt_idx_i,
    input  logic                  evt_lvl_i,
    output logic                  st_req_o,
    output logic [DATA_W-1:0]     st_addr_o,
    output logic [DATA_W-1:0]     st_data_o,
    input  logic                  st_ack_i,
    input  logic                  st_err_i,
    output logic                  st_err_flag_o,
    output logic                  map_en_o,
    output logic                  src_reset_o
);
    logic               method;
    logic               notif_valid;
    logic [DATA_W-1:0]  notif_addr;
    logic [31:0]        offset_hi;
    logic [DATA_W-1:0]  level;
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] take;

    tni_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (reg_wr_i),
        .addr_i        (reg_addr_i),
        .wdata_i       (reg_wdata_i),
        .level_i       (level),
        .rdata_o       (reg_rdata_o),
        .method_o      (method),
        .notif_valid_o (notif_valid),
        .notif_addr_o  (notif_addr),
        .offset_hi_o   (offset_hi),
        .map_en_o      (map_en_o),
        .src_reset_o   (src_reset_o)
    );

    tni_level #(.NUM_SRC(NUM_SRC)) u_level (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_vld_i     (evt_vld_i),
        .evt_idx_i     (evt_idx_i),
        .evt_lvl_i     (evt_lvl_i),
        .method_i      (method),
        .notif_valid_i (notif_valid),
        .take_i        (take),
        .level_o       (level),
        .pend_o        (pend)
    );

    tni_issue #(.NUM_SRC(NUM_SRC), .TRIG_CODE(TRIG_CODE)) u_issue (
        .clk           (clk),
        .rst_n         (rst_n),
        .pend_i        (pend),
        .method_i      (method),
        .notif_valid_i (notif_valid),
        .notif_addr_i  (notif_addr),
        .offset_hi_i   (offset_hi),
        .st_ack_i      (st_ack_i),
        .st_err_i      (st_err_i),
        .take_o        (take),
        .st_req_o      (st_req_o),
        .st_addr_o     (st_addr_o),
        .st_data_o     (st_data_o),
        .err_flag_o    (st_err_flag_o)
    );

    initial begin
        if (NUM_SRC < 1 || NUM_SRC > 63) $error("NUM_SRC out of range");
    end
endmodule

// File: tb/trig_notify_top_tb_top.sv
module trig_notify_top_tb_top;
    localparam int          CLK_PERIOD = 10;
    localparam int          NSRC       = 20;
    localparam logic [63:0] TRIG       = 64'h0000_0000_8000_0000;
    localparam logic [31:0] OFF_HI     = 32'h0012_0000;
    localparam logic [63:0] NOTIF_V    = 64'h0000_1234_5678_9001;
    localparam logic [63:0] NOTIF_A    = 64'h0000_1234_5678_9000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        evt_vld = 1'b0;
    logic [5:0]  evt_idx = '0;
    logic        evt_lvl = 1'b0;
    logic        st_req;
    logic [63:0] st_addr, st_data;
    logic        st_ack = 1'b0;
    logic        st_err = 1'b0;
    logic        st_err_flag, map_en, src_reset;

    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;
    bit          auto_ack = 1'b0;
    int          rnd_stores = 0;
    logic [63:0] exp_lvl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_notify_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .evt_vld_i(evt_vld), .evt_idx_i(evt_idx), .evt_lvl_i(evt_lvl),
        .st_req_o(st_req), .st_addr_o(st_addr), .st_data_o(st_data),
        .st_ack_i(st_ack), .st_err_i(st_err), .st_err_flag_o(st_err_flag),
        .map_en_o(map_en), .src_reset_o(src_reset)
    );

    function automatic logic [63:0] exp_data(input logic [31:0] hi, input int idx);
        return TRIG | {32'h0, hi} | 64'(idx);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic ev(input int idx, input logic lvl);
        @(negedge clk); evt_vld = 1'b1; evt_idx = 6'(idx); evt_lvl = lvl;
        @(negedge clk); evt_vld = 1'b0;
    endtask

    task automatic ack(input logic err);
        @(negedge clk); st_ack = 1'b1; st_err = err;
        @(negedge clk); st_ack = 1'b0; st_err = 1'b0;
    endtask

    // automatic acknowledger for the random phase, checks R4/R5 on each store
    initial begin
        forever begin
            @(negedge clk);
            if (auto_ack && st_req && !st_ack && ($urandom_range(0, 2) == 0)) begin
                rnd_stores++;
                chk("R4 random store address", st_addr, NOTIF_A);
                chk("R5 random store data upper", st_data & ~64'h1f, exp_data(OFF_HI, 0));
                chk("R5 random store source in range", 64'(st_data[4:0] < 5'(NSRC)), 64'd1);
                st_ack = 1'b1;
                @(negedge clk);
                st_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'd4, v); chk("R1 level after reset", v, 64'h0);
        rd(4'd0, v); chk("R1 ctrl after reset", v, 64'h0);
        rd(4'd2, v); chk("R1 notif after reset", v, 64'h0);
        rd(4'd7, v); chk("R1 unimplemented read", v, '1);
        rd(4'd15, v); chk("R1 unimplemented read top", v, '1);
        chk("R1 st_req after reset", 64'(st_req), 64'd0);
        chk("R1 map_en after reset", 64'(map_en), 64'd0);
        chk("R1 err flag after reset", 64'(st_err_flag), 64'd0);
        chk("R1 src_reset after reset", 64'(src_reset), 64'd0);

        wr(4'd2, NOTIF_V);
        wr(4'd3, {OFF_HI, 32'hdead_beef});

        // R11 store one cycle after the event edge; R4/R5 contents
        ev(3, 1'b1); exp_lvl[60] = 1'b1;
        chk("R11 no request before next edge", 64'(st_req), 64'd0);
        @(posedge clk); #1;
        chk("R11 request after event", 64'(st_req), 64'd1);
        chk("R4 store address", st_addr, NOTIF_A);
        chk("R5 store data src3", st_data, exp_data(OFF_HI, 3));
        rd(4'd4, v); chk("R2 level bit for source 3", v, exp_lvl);

        // R7 coalescing and ordering while source 3 is in flight
        ev(3, 1'b1);
        ev(1, 1'b1); exp_lvl[62] = 1'b1;
        ev(1, 1'b1);
        repeat (3) @(negedge clk);
        chk("R6 request held", 64'(st_req), 64'd1);
        chk("R6 data held", st_data, exp_data(OFF_HI, 3));
        ack(1'b0);
        @(posedge clk); #1;
        chk("R7 lowest pending issued first", st_data, exp_data(OFF_HI, 1));
        ack(1'b0);
        @(posedge clk); #1;
        chk("R7 next pending source", st_data, exp_data(OFF_HI, 3));
        ack(1'b0);
        repeat (4) @(posedge clk); #1;
        chk("R7 coalesced events give no extra store", 64'(st_req), 64'd0);

        // R11 lowering event
        ev(3, 1'b0); exp_lvl[60] = 1'b0;
        repeat (3) @(posedge clk); #1;
        chk("R11 lowering issues no store", 64'(st_req), 64'd0);
        rd(4'd4, v); chk("R11 level bit cleared", v, exp_lvl);

        // R2 out-of-range source
        ev(25, 1'b1);
        repeat (3) @(posedge clk); #1;
        chk("R2 out-of-range no store", 64'(st_req), 64'd0);
        rd(4'd4, v); chk("R2 out-of-range level unchanged", v, exp_lvl);

        // R3 method bit
        wr(4'd0, 64'h8000_0000_0000_0000);
        ev(6, 1'b1);
        ev(1, 1'b0);
        repeat (3) @(posedge clk); #1;
        chk("R3 method blocks store", 64'(st_req), 64'd0);
        rd(4'd4, v); chk("R3 method freezes level", v, exp_lvl);
        wr(4'd0, 64'h0);

        // R4 valid bit clear blocks stores
        wr(4'd2, NOTIF_A);
        ev(7, 1'b1); exp_lvl[56] = 1'b1;
        repeat (3) @(posedge clk); #1;
        chk("R4 invalid address no store", 64'(st_req), 64'd0);
        rd(4'd4, v); chk("R4 level still tracked", v, exp_lvl);

        // R8 source reset pulse
        wr(4'd0, 64'h4000_0000_0000_0005);
        chk("R8 reset pulse high", 64'(src_reset), 64'd1);
        @(negedge clk);
        chk("R8 reset pulse one cycle", 64'(src_reset), 64'd0);
        rd(4'd0, v); chk("R8 ctrl stores value", v, 64'h4000_0000_0000_0005);
        wr(4'd0, 64'h0);
        chk("R8 no pulse without bit 62", 64'(src_reset), 64'd0);

        // R9 map enable
        wr(4'd1, 64'h00ab_0000_0000_0001);
        chk("R9 map enable set", 64'(map_en), 64'd1);
        rd(4'd1, v); chk("R9 cap stores value", v, 64'h00ab_0000_0000_0001);
        wr(4'd1, 64'h00cd_0000_0000_0000);
        chk("R9 map enable cleared", 64'(map_en), 64'd0);
        rd(4'd1, v); chk("R9 cap stores cleared value", v, 64'h00cd_0000_0000_0000);

        // R10 sticky error
        wr(4'd2, NOTIF_V);
        ev(2, 1'b1); exp_lvl[61] = 1'b1;
        @(posedge clk); #1;
        chk("R10 store before error", st_data, exp_data(OFF_HI, 2));
        ack(1'b1);
        chk("R10 error flag set", 64'(st_err_flag), 64'd1);
        repeat (3) @(posedge clk); #1;
        chk("R10 no retry", 64'(st_req), 64'd0);
        chk("R10 error flag sticky", 64'(st_err_flag), 64'd1);

        // random phase (R2 level model, R4/R5 checked by acknowledger)
        auto_ack = 1'b1;
        for (int k = 0; k < 400; k++) begin
            int idx;
            logic lvl;
            idx = $urandom_range(0, 31);
            lvl = 1'($urandom_range(0, 1));
            ev(idx, lvl);
            if (idx < NSRC) exp_lvl[63 - idx] = lvl;
        end
        repeat (300) @(posedge clk);
        auto_ack = 1'b0;
        #1;
        chk("R7 random phase drained", 64'(st_req), 64'd0);
        chk("R2 random phase produced stores", 64'(rnd_stores > 0), 64'd1);
        rd(4'd4, v); chk("R2 random level model", v, exp_lvl);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule